// File: doc/BRIEF.md
# Shape-Shifting Tower-Field AES S-box

This block computes the AES SubBytes substitution through a composite-field datapath. The datapath can take any one of 32 internal shapes. Each shape is a pair of tower constants (a GF(4) constant `phi` and a GF(16) constant `lam`) together with a change-of-basis matrix and its inverse. Every shape gives exactly the same byte at the output. The voltages inside the datapath differ from shape to shape, so the supply current no longer follows the processed value in a fixed way.

A selection LFSR picks the shape. Encryptor and decryptor load the same seed into it, much as they share a key. The LFSR steps once per block, on the block-start strobe, and the low bits of its state become the shape index for the block that follows.

A second LFSR steps on every clock. It picks two other shapes whose inverse basis change is applied to the same intermediate value in parallel with the real one. These decoy results are written to internal registers that never reach the port.

The block sits inside an AES round. It is fed one byte per clock and returns the substituted byte one clock later.

Top module: `sbx_iso_sbox`

## Requirements
- R1: While `rst_n` is low, `dout` is 0x00.
- R2: One clock after `din` is sampled, `dout` equals the AES S-box of it: the multiplicative inverse modulo x^8+x^4+x^3+x+1 (zero maps to zero), then the affine step with constant 0x63. For example 0x00→0x63, 0x01→0x7C, 0x53→0xED, 0xFF→0x16.
- R3: The result of R2 is the same whichever of the 32 shapes is active, and it does not depend on the seed.
- R4: The composite-field inverse inside the active shape returns the field inverse for a nonzero operand and zero for zero.
- R5: On a clock with `blk_start` high, the shape index is loaded from the low 5 bits of the selection LFSR, and that LFSR steps. With `blk_start` low, the index holds. The new index applies from the next clock on. `seed_load` writes `seed_val` into the selection LFSR.
- R6: Every shape uses `phi` of 2 or 3 and `lam` in 8..15.
- R7: A zero seed is replaced by a fixed nonzero value, so neither LFSR is ever zero. S-box results stay correct after a zero seed.
- R8: The decoy LFSR steps on every clock that has no seed load. Each decoy index differs from the active index. Decoy results have no effect on `dout`.
- R9: `blk_start` may be asserted on any clock, including every clock, and may coincide with `seed_load`, without disturbing R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed_val` into both LFSRs (the decoy LFSR takes it XORed with a salt) |
| seed_val | input | 16 | Shared seed |
| blk_start | input | 1 | Block-start strobe; latches a new shape index |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Registered S-box result |

## Verification
The hardest condition to reach from the ports is having each of the 32 shapes active while every input byte is applied. The shape index is internal and comes from a pseudorandom sequence. The stimulus therefore runs dozens of blocks per seed, each block a full 256-byte sweep in a shifted order, over several seeds including zero. The low five LFSR bits then pass through every value many times. Short blocks and a strobe on every clock stress the index changes. Assertions confirm the index capture and the correctness of the field inverse in whichever shape is active.

// File: rtl/sbx_iso_pkg.sv
package sbx_iso_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned MAP_W  = BYTE_W * BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;

   // one isomorphic shape: tower constants and both basis-change matrices
   // fwd[8*i +: 8] = image of standard-basis bit i, bwd[8*j +: 8] = image of tower bit j
   typedef struct packed {
      logic [1:0]       phi;
      logic [3:0]       lam;
      logic [MAP_W-1:0] fwd;
      logic [MAP_W-1:0] bwd;
   } iso_cfg_t;

   // GF(4) = GF(2)[w]/(w^2+w+1)
   function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
      logic hh;
      hh = a[1] & b[1];
      return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
   endfunction

   function automatic logic [1:0] gf4_sq(input logic [1:0] a);
      return {a[1], a[1] ^ a[0]};
   endfunction

   // GF(16) = GF(4)[y]/(y^2+y+phi)
   function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b,
                                           input logic [1:0] phi);
      logic [1:0] hh, hi, lo;
      hh = gf4_mul(a[3:2], b[3:2]);
      hi = hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]);
      lo = gf4_mul(hh, phi) ^ gf4_mul(a[1:0], b[1:0]);
      return {hi, lo};
   endfunction

   function automatic logic [3:0] gf16_inv(input logic [3:0] a, input logic [1:0] phi);
      logic [1:0] h, l, d, di;
      h  = a[3:2];
      l  = a[1:0];
      d  = gf4_mul(gf4_sq(h), phi) ^ gf4_mul(h, l) ^ gf4_sq(l);
      di = gf4_sq(d);
      return {gf4_mul(di, h), gf4_mul(di, h ^ l)};
   endfunction

   // GF(256) = GF(16)[z]/(z^2+z+lam)
   function automatic byte_t gf256_mul(input byte_t a, input byte_t b,
                                       input logic [1:0] phi, input logic [3:0] lam);
      logic [3:0] hh, hi, lo;
      hh = gf16_mul(a[7:4], b[7:4], phi);
      hi = hh ^ gf16_mul(a[7:4], b[3:0], phi) ^ gf16_mul(a[3:0], b[7:4], phi);
      lo = gf16_mul(hh, lam, phi) ^ gf16_mul(a[3:0], b[3:0], phi);
      return {hi, lo};
   endfunction

   function automatic byte_t lin_apply(input logic [MAP_W-1:0] cols, input byte_t v);
      byte_t r;
      r = '0;
      for (int i = 0; i < BYTE_W; i++)
         if (v[i]) r ^= cols[BYTE_W*i +: BYTE_W];
      return r;
   endfunction

   function automatic byte_t aes_affine(input byte_t a);
      return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]}
               ^ {a[3:0], a[7:4]} ^ 8'h63;
   endfunction

   // x^8+x^4+x^3+x+1 evaluated in the tower field
   function automatic byte_t aes_poly_eval(input byte_t b, input logic [1:0] phi,
                                           input logic [3:0] lam);
      byte_t b2, b3, b4, b8;
      b2 = gf256_mul(b, b, phi, lam);
      b3 = gf256_mul(b2, b, phi, lam);
      b4 = gf256_mul(b2, b2, phi, lam);
      b8 = gf256_mul(b4, b4, phi, lam);
      return b8 ^ b4 ^ b3 ^ b ^ 8'h01;
   endfunction

   // shape idx: bit4 picks phi, bits3:1 pick lam, bit0 picks a conjugate root
   function automatic iso_cfg_t cfg_build(input int unsigned idx);
      iso_cfg_t   c;
      logic [4:0] ix;
      byte_t      beta, pw, img;
      logic       found;
      ix    = idx[4:0];
      c.phi = ix[4] ? 2'd3 : 2'd2;
      c.lam = {1'b1, ix[3:1]};
      beta  = '0;
      found = 1'b0;
      for (int k = 2; k < 256; k++) begin
         if (!found && (aes_poly_eval(8'(k), c.phi, c.lam) == '0)) begin
            beta  = 8'(k);
            found = 1'b1;
         end
      end
      if (ix[0]) beta = gf256_mul(beta, beta, c.phi, c.lam);
      pw = 8'h01;
      for (int i = 0; i < BYTE_W; i++) begin
         c.fwd[BYTE_W*i +: BYTE_W] = pw;
         pw = gf256_mul(pw, beta, c.phi, c.lam);
      end
      c.bwd = '0;
      for (int a = 0; a < 256; a++) begin
         img = lin_apply(c.fwd, 8'(a));
         for (int j = 0; j < BYTE_W; j++)
            if (img == (8'h01 << j)) c.bwd[BYTE_W*j +: BYTE_W] = 8'(a);
      end
      return c;
   endfunction

endpackage

// File: rtl/sbx_lfsr.sv
module sbx_lfsr #(
   parameter int unsigned   W       = 16,
   parameter int unsigned   OUT_W   = 5,
   parameter logic [W-1:0]  TAPS    = 16'hB400,
   parameter logic [W-1:0]  RST_VAL = 16'h0001,
   parameter logic [W-1:0]  SUB_VAL = 16'h0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [W-1:0]     seed_i,
   input  logic             step_i,
   output logic [OUT_W-1:0] bits_o
);

   if (OUT_W > W) begin : g_bad_out
      $error("sbx_lfsr: OUT_W larger than W");
   end
   if (!TAPS[W-1]) begin : g_bad_taps
      $error("sbx_lfsr: top tap must be set");
   end
   if (SUB_VAL == '0 || RST_VAL == '0) begin : g_bad_sub
      $error("sbx_lfsr: zero lockup value");
   end

   logic [W-1:0] state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (load_i)
         state_d = (seed_i == '0) ? SUB_VAL : seed_i;
      else if (step_i)
         state_d = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RST_VAL;
      else        state_q <= state_d;
   end

   assign bits_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/sbx_cfg_rom.sv
module sbx_cfg_rom
   import sbx_iso_pkg::*;
#(
   parameter int unsigned N_SETS = 32,
   parameter int unsigned N_DEC  = 2,
   localparam int unsigned IDX_W = $clog2(N_SETS)
) (
   input  logic [IDX_W-1:0] act_idx_i,
   output iso_cfg_t         act_cfg_o,
   input  logic [IDX_W-1:0] dec_idx_i [N_DEC],
   output logic [MAP_W-1:0] dec_bwd_o [N_DEC]
);

   iso_cfg_t tbl [N_SETS];

   for (genvar g = 0; g < N_SETS; g++) begin : g_ent
      localparam iso_cfg_t ENT = cfg_build(g);
      assign tbl[g] = ENT;
   end

   assign act_cfg_o = tbl[act_idx_i];

   for (genvar k = 0; k < N_DEC; k++) begin : g_dec
      assign dec_bwd_o[k] = tbl[dec_idx_i[k]].bwd;
   end

endmodule

// File: rtl/sbx_lin_map.sv
module sbx_lin_map
   import sbx_iso_pkg::*;
(
   input  logic [MAP_W-1:0] cols_i,
   input  byte_t            v_i,
   output byte_t            y_o
);

   byte_t part [BYTE_W+1];

   assign part[0] = '0;
   for (genvar g = 0; g < BYTE_W; g++) begin : g_col
      assign part[g+1] = part[g] ^ (cols_i[BYTE_W*g +: BYTE_W] & {BYTE_W{v_i[g]}});
   end
   assign y_o = part[BYTE_W];

endmodule

// File: rtl/sbx_tower_inv.sv
module sbx_tower_inv
   import sbx_iso_pkg::*;
(
   input  byte_t      a_i,
   input  logic [1:0] phi_i,
   input  logic [3:0] lam_i,
   output byte_t      y_o
);

   logic [3:0] hi, lo, hsq, lsq, hl, dlt, dinv;

   assign hi = a_i[7:4];
   assign lo = a_i[3:0];

   always_comb begin
      hsq  = gf16_mul(hi, hi, phi_i);
      lsq  = gf16_mul(lo, lo, phi_i);
      hl   = gf16_mul(hi, lo, phi_i);
      dlt  = gf16_mul(hsq, lam_i, phi_i) ^ hl ^ lsq;
      dinv = gf16_inv(dlt, phi_i);
      y_o  = {gf16_mul(dinv, hi, phi_i), gf16_mul(dinv, hi ^ lo, phi_i)};
   end

endmodule

// File: rtl/sbx_iso_sbox.sv
module sbx_iso_sbox
   import sbx_iso_pkg::*;
#(
   parameter int unsigned        LFSR_W   = 16,
   parameter int unsigned        N_SETS   = 32,
   parameter int unsigned        N_DEC    = 2,
   parameter logic [LFSR_W-1:0]  SEL_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0]  DEC_TAPS = 16'hD008,
   parameter logic [LFSR_W-1:0]  DEC_SALT = 16'hA5C3,
   parameter logic [LFSR_W-1:0]  RST_SEED = 16'h0001,
   parameter logic [LFSR_W-1:0]  ZERO_SUB = 16'h6D2B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load,
   input  logic [LFSR_W-1:0] seed_val,
   input  logic              blk_start,
   input  logic [7:0]        din,
   output logic [7:0]        dout
);

   localparam int unsigned IDX_W = $clog2(N_SETS);
   localparam int unsigned OFF_W = IDX_W - 1;

   if (N_SETS < 4 || N_SETS > 32 || (1 << IDX_W) != N_SETS) begin : g_bad_sets
      $error("sbx_iso_sbox: N_SETS must be a power of two in 4..32");
   end
   if (N_DEC < 1 || 2*N_DEC > N_SETS) begin : g_bad_dec
      $error("sbx_iso_sbox: N_DEC out of range");
   end
   if (LFSR_W < IDX_W) begin : g_bad_lfsr
      $error("sbx_iso_sbox: LFSR narrower than index");
   end

   // ---------------- shape selection ----------------
   logic [IDX_W-1:0] sel_low, sel_idx;
   logic [OFF_W-1:0] dec_low, mix;
   logic [IDX_W-1:0] dec_idx [N_DEC];
   byte_t            decoy_q [N_DEC];

   sbx_lfsr #(.W(LFSR_W), .OUT_W(IDX_W), .TAPS(SEL_TAPS),
              .RST_VAL(RST_SEED), .SUB_VAL(ZERO_SUB)) u_sel_lfsr (
      .clk(clk), .rst_n(rst_n), .load_i(seed_load), .seed_i(seed_val),
      .step_i(blk_start), .bits_o(sel_low));

   sbx_lfsr #(.W(LFSR_W), .OUT_W(OFF_W), .TAPS(DEC_TAPS),
              .RST_VAL(RST_SEED ^ DEC_SALT), .SUB_VAL(ZERO_SUB)) u_dec_lfsr (
      .clk(clk), .rst_n(rst_n), .load_i(seed_load), .seed_i(seed_val ^ DEC_SALT),
      .step_i(1'b1), .bits_o(dec_low));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_idx <= '0;
      else if (blk_start) sel_idx <= sel_low;
   end

   // decoy history folded into the decoy offset
   always_comb begin
      mix = dec_low;
      for (int k = 0; k < int'(N_DEC); k++)
         for (int b = 0; b < int'(BYTE_W); b++)
            mix[b % OFF_W] ^= decoy_q[k][b];
   end

   // odd offsets never hit the active index; distinct k keep decoys apart
   for (genvar k = 0; k < N_DEC; k++) begin : g_didx
      assign dec_idx[k] = sel_idx ^ {mix, 1'b1} ^ IDX_W'(2*k);
   end

   // ---------------- parameter table ----------------
   iso_cfg_t         act_cfg;
   logic [MAP_W-1:0] dec_bwd [N_DEC];

   sbx_cfg_rom #(.N_SETS(N_SETS), .N_DEC(N_DEC)) u_rom (
      .act_idx_i(sel_idx), .act_cfg_o(act_cfg),
      .dec_idx_i(dec_idx), .dec_bwd_o(dec_bwd));

   // ---------------- datapath ----------------
   byte_t mapped, pre, back;

   sbx_lin_map u_fwd (.cols_i(act_cfg.fwd), .v_i(din), .y_o(mapped));

   sbx_tower_inv u_inv (.a_i(mapped), .phi_i(act_cfg.phi), .lam_i(act_cfg.lam), .y_o(pre));

   sbx_lin_map u_bwd (.cols_i(act_cfg.bwd), .v_i(pre), .y_o(back));

   for (genvar k = 0; k < N_DEC; k++) begin : g_decoy
      byte_t dback;
      sbx_lin_map u_dmap (.cols_i(dec_bwd[k]), .v_i(pre), .y_o(dback));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) decoy_q[k] <= '0;
         else        decoy_q[k] <= aes_affine(dback);
      end
   end

   byte_t dout_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= aes_affine(back);
   end
   assign dout = dout_q;

endmodule

// File: rtl/sbx_iso_sbox_chk.sv
module sbx_iso_sbox_chk
   import sbx_iso_pkg::*;
#(
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned LFSR_W = 16,
   parameter int unsigned N_DEC  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              blk_start,
   input logic              seed_load,
   input logic [IDX_W-1:0]  sel_idx,
   input logic [IDX_W-1:0]  dec_idx [N_DEC],
   input logic [1:0]        cfg_phi,
   input logic [3:0]        cfg_lam,
   input byte_t             inv_in,
   input byte_t             inv_out,
   input logic [LFSR_W-1:0] sel_st,
   input logic [LFSR_W-1:0] dec_st
);

   // R4
   inv_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_in != '0) |-> (gf256_mul(inv_in, inv_out, cfg_phi, cfg_lam) == 8'h01));

   // R4
   inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_in == '0) |-> (inv_out == '0));

   // R5
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_start |=> $stable(sel_idx));

   // R5
   idx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (sel_idx == $past(sel_st[IDX_W-1:0])));

   // R6
   cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_phi == 2'd2) || (cfg_phi == 2'd3)) && cfg_lam[3]);

   // R7
   lfsr_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_st != '0) && (dec_st != '0));

   // R8
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seed_load |=> (dec_st != $past(dec_st)));

   for (genvar k = 0; k < N_DEC; k++) begin : g_dk
      // R8
      dec_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_idx[k] != sel_idx);
   end

endmodule

bind sbx_iso_sbox sbx_iso_sbox_chk #(.IDX_W(IDX_W), .LFSR_W(LFSR_W), .N_DEC(N_DEC)) i_chk (
   .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .seed_load(seed_load),
   .sel_idx(sel_idx), .dec_idx(dec_idx),
   .cfg_phi(act_cfg.phi), .cfg_lam(act_cfg.lam),
   .inv_in(mapped), .inv_out(pre),
   .sel_st(u_sel_lfsr.state_q), .dec_st(u_dec_lfsr.state_q));

// File: tb/test_sbx_iso_sbox.sv
module test_sbx_iso_sbox;

   localparam int PERIOD = 10;
   localparam int NBLK   = 36;
   localparam int NVEC   = 6;
   // {seed, bytes per block (0 = 256), requirement selector}
   localparam logic [27:0] VEC [NVEC] = '{
      {16'h1ACE, 8'd0,  4'd3},
      {16'h0000, 8'd0,  4'd7},
      {16'hC0DE, 8'd16, 4'd3},
      {16'hFFFF, 8'd1,  4'd9},
      {16'h8001, 8'd0,  4'd6},
      {16'h5A5A, 8'd3,  4'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [15:0] seed_val = '0;
   logic        blk_start = 1'b0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   logic [7:0] sref [256];

   always #(PERIOD/2) clk = ~clk;

   sbx_iso_sbox i_sbx_iso_sbox (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
      .blk_start(blk_start), .din(din), .dout(dout));

   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
   endfunction

   function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r, t;
      r = '0;
      t = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r ^= t;
         t = xt(t);
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic feed(input logic [7:0] d, input logic s, input string tag);
      din = d;
      blk_start = s;
      @(posedge clk); #1;
      blk_start = 1'b0;
      chk(tag, dout, sref[d]);
   endtask

   task automatic reseed(input logic [15:0] s, input logic [7:0] d, input logic st,
                         input string tag);
      seed_val = s;
      seed_load = 1'b1;
      din = d;
      blk_start = st;
      @(posedge clk); #1;
      seed_load = 1'b0;
      blk_start = 1'b0;
      chk(tag, dout, sref[d]);
   endtask

   initial begin
      // reference table: brute-force inverse plus affine step
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv, a;
         inv = '0;
         for (int y = 1; y < 256; y++)
            if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         a = inv;
         sref[x] = a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]}
                   ^ {a[3:0], a[7:4]} ^ 8'h63;
      end

      // R1: reset holds output at zero
      repeat (3) @(posedge clk);
      #1;
      din = 8'h5A;
      @(posedge clk); #1;
      chk("R1 reset", dout, 8'h00);
      rst_n = 1'b1;

      // R2: literal values
      din = 8'h00; @(posedge clk); #1; chk("R2 00", dout, 8'h63);
      din = 8'h01; @(posedge clk); #1; chk("R2 01", dout, 8'h7C);
      din = 8'h53; @(posedge clk); #1; chk("R2 53", dout, 8'hED);
      din = 8'hFF; @(posedge clk); #1; chk("R2 FF", dout, 8'h16);
      din = 8'h10; @(posedge clk); #1; chk("R2 10", dout, 8'hCA);

      // R4: zero and one operands of the inverse
      feed(8'h00, 1'b1, "R4 zero");
      feed(8'h01, 1'b0, "R4 one");

      // vector table: seeds and block shapes
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] s;
         int          len;
         string       tag;
         s   = VEC[v][27:12];
         len = (VEC[v][11:4] == 0) ? 256 : int'(VEC[v][11:4]);
         case (VEC[v][3:0])
            4'd7:    tag = "R7 zero seed";
            4'd9:    tag = "R9 strobe every byte";
            4'd6:    tag = "R6 shape sweep";
            4'd8:    tag = "R8 decoys no effect";
            default: tag = "R3 shape sweep";
         endcase
         reseed(s, 8'h9C, 1'b0, "R5 seed load");
         for (int b = 0; b < NBLK; b++)
            for (int i = 0; i < len; i++)
               feed(8'(i + b*91), (i == 0), tag);
      end

      // R9: seed load and strobe in the same clock, then back-to-back strobes
      reseed(16'h3141, 8'hA7, 1'b1, "R9 load with strobe");
      for (int i = 0; i < 64; i++)
         feed(8'(i*7 + 3), 1'b1, "R9 back to back");

      // R5: reseed mid-block
      feed(8'h21, 1'b1, "R5 block");
      reseed(16'h2718, 8'h42, 1'b0, "R5 mid-block reseed");
      feed(8'h43, 1'b0, "R5 after reseed");

      // R1: reset in mid-run
      rst_n = 1'b0;
      #1;
      chk("R1 async reset", dout, 8'h00);
      @(posedge clk); #1;
      chk("R1 reset held", dout, 8'h00);
      rst_n = 1'b1;
      feed(8'hFF, 1'b1, "R2 after reset");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD*200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule